// File: doc/BRIEF.md
# Four-Lane Seven-to-One Pixel Word Deserializer

This block sits behind four already-sampled serial data lanes and one forwarded-clock lane. Each lane delivers one bit per fast clock cycle. Every pixel period spans seven fast cycles. The forwarded-clock lane repeats a fixed seven-bit shape. The block searches for that shape to find where each seven-bit group starts. It then places the four seven-bit groups side by side to form a 28-bit pixel word. The word holds 24 colour bits and four control lines: line sync, frame sync, data enable and one spare. The block also drives a regenerated pixel strobe whose falling edge marks the moment the word is valid.

The block declares lock only after the clock-lane shape has been seen repeatedly in one phase. After lock, it tolerates a single corrupted period. Two corrupted periods in a row drop lock and restart the phase search. While the block is unlocked, and while the active-low power-down input is held low, the output word holds its last value and the strobe stays low. The legal pixel period is 25 ns to 50 ns, so the fast clock runs at seven times the pixel rate.

Top module: `pix_deser_top`

## Requirements
- R1: A frame starts where the clock lane begins the time-ordered sequence 1,1,0,0,0,1,1. The j-th bit (j = 0..6) that lane k delivers in a frame appears on `pix_data[7k+j]`. Bits 23:0 are colour, bit 24 is line sync, bit 25 is frame sync, bit 26 is data enable and bit 27 is the spare control. All of these are passed through unchanged.
- R2: While the block is locked and powered, `pix_strobe` is high for 4 fast cycles and low for 3 in every frame. `pix_data` changes only while `pix_strobe` is high. At each falling edge of the strobe, `pix_data` holds the most recently completed frame.
- R3: `locked` rises only after the clock-lane sequence has matched at 4 consecutive frame boundaries of the same phase. It stays low while fewer than 4 such matches have occurred.
- R4: While locked, a single frame whose clock lane does not match leaves `locked` high. Two consecutive mismatching frames drop `locked`, and the block then searches all seven phases again and relocks.
- R5: While `locked` is low, `pix_data` keeps its previous value and `pix_strobe` stays low.
- R6: While `pwr_n` is low, `pix_data` keeps its previous value and `pix_strobe` stays low, but lock tracking continues. Once `pwr_n` returns high, capture resumes at the next frame boundary.
- R7: After reset, `pix_data` is 0, `pix_strobe` is 0 and `locked` is 0.
- R8: Lock is reached whichever of the seven bit phases the incoming stream starts in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_n | input | 1 | Active-low power-down; low freezes the output word |
| lane_in | input | 4 | One sampled bit per data lane per fast cycle |
| clk_lane | input | 1 | One sampled bit of the forwarded-clock lane per fast cycle |
| pix_data | output | 28 | Rebuilt pixel word |
| pix_strobe | output | 1 | Regenerated pixel strobe; falling edge marks valid data |
| locked | output | 1 | High while frame alignment is established |

## Verification
A wrong frame phase or a swapped lane shows up at the first strobe fall after lock as a word whose four lane groups do not form one consistent frame. A wrong phase also shows up as a word that is not the frame just completed. A miscounting match or miss counter moves the rise or fall of `locked` by one or more frames. This is checked within a few pixel periods after the stream starts, and just after two corrupted frames. A freeze path that leaks shows at the ports within one frame of power-down or loss of lock, as a changed word or a strobe that still pulses.

// File: rtl/pix_deser_pkg.sv
package pix_deser_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned FRAME_DEF = 7;
  // time-ordered 1,1,0,0,0,1,1 with the first received bit at index 0
  localparam logic [FRAME_DEF-1:0] CLK_SHAPE_DEF = 7'b1100011;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } align_st_e;
endpackage

// File: rtl/pix_lane_shift.sv
module pix_lane_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [W-1:0] win
);
  logic [W-1:0] win_d;

  // newest bit enters at the top, so the oldest of the last W bits sits at 0
  always_comb win_d = {ser_in, win[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_d;
  end
endmodule

// File: rtl/pix_frame_align.sv
module pix_frame_align
  import pix_deser_pkg::*;
#(
  parameter int unsigned     FRAME  = 7,
  parameter logic [FRAME-1:0] SHAPE = 7'b1100011,
  parameter int unsigned     LOCK_N = 4,
  parameter int unsigned     MISS_N = 2,
  localparam int unsigned    PW     = $clog2(FRAME),
  localparam int unsigned    GW     = $clog2(LOCK_N + 1),
  localparam int unsigned    BW     = $clog2(MISS_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FRAME-1:0] clk_win,
  output logic             frame_end,
  output logic             locked,
  output logic             locked_nxt,
  output logic [PW-1:0]    phase_nxt
);
  logic [PW-1:0] phase_q, phase_d;
  align_st_e     st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] miss_q, miss_d;
  logic          hit;

  assign frame_end  = (phase_q == PW'(FRAME - 1));
  assign hit        = (clk_win == SHAPE);
  assign locked     = (st_q == ST_LOCKED);
  assign locked_nxt = (st_d == ST_LOCKED);
  assign phase_nxt  = phase_d;

  always_comb begin
    phase_d = frame_end ? '0 : phase_q + PW'(1);
    st_d    = st_q;
    good_d  = good_q;
    miss_d  = miss_q;
    if (frame_end) begin
      case (st_q)
        ST_SEARCH: begin
          if (hit) begin
            if (good_q == GW'(LOCK_N - 1)) begin
              st_d   = ST_LOCKED;
              good_d = '0;
            end else begin
              good_d = good_q + GW'(1);
            end
          end else begin
            good_d  = '0;
            phase_d = phase_q;   // slip one bit: test the next phase
          end
        end
        ST_LOCKED: begin
          if (hit) begin
            miss_d = '0;
          end else if (miss_q == BW'(MISS_N - 1)) begin
            st_d    = ST_SEARCH;
            miss_d  = '0;
            phase_d = phase_q;
          end else begin
            miss_d = miss_q + BW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      st_q    <= ST_SEARCH;
      good_q  <= '0;
      miss_q  <= '0;
    end else begin
      phase_q <= phase_d;
      st_q    <= st_d;
      good_q  <= good_d;
      miss_q  <= miss_d;
    end
  end

  // R3
  lock_after_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(good_q) == GW'(LOCK_N - 1)));

  // R4
  drop_after_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(miss_q) == BW'(MISS_N - 1)));

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PW'(FRAME));
endmodule

// File: rtl/pix_word_out.sv
module pix_word_out #(
  parameter int unsigned  WW        = 28,
  parameter int unsigned  PW        = 3,
  parameter int unsigned  STROBE_HI = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          frame_end,
  input  logic          locked_nxt,
  input  logic [PW-1:0] phase_nxt,
  input  logic [WW-1:0] word_in,
  output logic [WW-1:0] pix_data,
  output logic          pix_strobe
);
  logic          cap_en;
  logic [WW-1:0] data_d;
  logic          strb_d;

  assign cap_en = frame_end & locked_nxt & pwr_n;

  always_comb begin
    data_d = cap_en ? word_in : pix_data;
    strb_d = locked_nxt & pwr_n & (phase_nxt < PW'(STROBE_HI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_data   <= '0;
      pix_strobe <= 1'b0;
    end else begin
      pix_data   <= data_d;
      pix_strobe <= strb_d;
    end
  end

  // R2
  change_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_data) |-> pix_strobe);

  // R6
  powerdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> ($stable(pix_data) && !pix_strobe));

  // R5
  unlocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_nxt |=> ($stable(pix_data) && !pix_strobe));
endmodule

// File: rtl/pix_deser_top.sv
module pix_deser_top
  import pix_deser_pkg::*;
#(
  parameter int unsigned      LANES     = LANES_DEF,
  parameter int unsigned      FRAME     = FRAME_DEF,
  parameter logic [FRAME-1:0] SHAPE     = CLK_SHAPE_DEF,
  parameter int unsigned      LOCK_N    = 4,
  parameter int unsigned      MISS_N    = 2,
  parameter int unsigned      STROBE_HI = 4,
  localparam int unsigned     WW        = LANES * FRAME,
  localparam int unsigned     PW        = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [LANES-1:0] lane_in,
  input  logic             clk_lane,
  output logic [WW-1:0]    pix_data,
  output logic             pix_strobe,
  output logic             locked
);
  logic [1:0]       rst_sync;
  logic             rst_n_int;
  logic [WW-1:0]    word_bus;
  logic [FRAME-1:0] clk_win;
  logic             frame_end;
  logic             locked_nxt;
  logic [PW-1:0]    phase_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pix_lane_shift #(.W(FRAME)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .ser_in (lane_in[k]),
      .win    (word_bus[k*FRAME +: FRAME])
    );
  end

  pix_lane_shift #(.W(FRAME)) u_clk_shift (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .ser_in (clk_lane),
    .win    (clk_win)
  );

  pix_frame_align #(
    .FRAME  (FRAME),
    .SHAPE  (SHAPE),
    .LOCK_N (LOCK_N),
    .MISS_N (MISS_N)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clk_win    (clk_win),
    .frame_end  (frame_end),
    .locked     (locked),
    .locked_nxt (locked_nxt),
    .phase_nxt  (phase_nxt)
  );

  pix_word_out #(
    .WW        (WW),
    .PW        (PW),
    .STROBE_HI (STROBE_HI)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .pwr_n      (pwr_n),
    .frame_end  (frame_end),
    .locked_nxt (locked_nxt),
    .phase_nxt  (phase_nxt),
    .word_in    (word_bus),
    .pix_data   (pix_data),
    .pix_strobe (pix_strobe)
  );

  // R5
  strobe_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    pix_strobe |-> locked);
endmodule

// File: tb/tb_pix_deser_top.sv
module tb_pix_deser_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_n;
  logic [3:0]  lane_in;
  logic        clk_lane;
  logic [27:0] pix_data;
  logic        pix_strobe;
  logic        locked;

  int total = 0;
  int bad   = 0;
  int cap_cnt = 0;
  bit done = 1'b0;
  logic [6:0] cur_f = '0;
  logic [6:0] next_f = 7'd10;
  localparam logic [6:0] SHAPE_T = 7'b1100011;

  always #2 clk = ~clk;

  pix_deser_top dut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lane_in(lane_in),
    .clk_lane(clk_lane), .pix_data(pix_data), .pix_strobe(pix_strobe),
    .locked(locked)
  );

  function automatic logic [27:0] word_of(input logic [6:0] f);
    word_of = {f + 7'd3, f + 7'd2, f + 7'd1, f};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic [6:0] f, input int j, input bit corrupt);
    logic [27:0] w;
    w = word_of(f);
    @(negedge clk);
    for (int k = 0; k < 4; k++) lane_in[k] = w[7*k + j];
    clk_lane = corrupt ? 1'b0 : SHAPE_T[j];
  endtask

  task automatic send_frame(input bit corrupt);
    cur_f = next_f;
    for (int j = 0; j < 7; j++) send_bit(next_f, j, corrupt);
    next_f = next_f + 7'd1;
  endtask

  task automatic send_frames(input int n);
    for (int i = 0; i < n; i++) send_frame(1'b0);
  endtask

  // strobe monitor: checks every falling edge of the strobe
  logic prev_strb;
  int   hi_cnt;
  bit   seen_rise;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_strb = 1'b0; hi_cnt = 0; seen_rise = 1'b0;
    end else begin
      if (pix_strobe && !prev_strb) begin seen_rise = 1'b1; hi_cnt = 0; end
      if (pix_strobe) hi_cnt++;
      if (prev_strb && !pix_strobe) begin
        cap_cnt++;
        chk(pix_data == word_of(pix_data[6:0]), "R1 lane placement",
            {4'h0, pix_data}, {4'h0, word_of(pix_data[6:0])});
        chk(pix_data[6:0] == cur_f - 7'd1, "R2 latest frame at strobe fall",
            {25'h0, pix_data[6:0]}, {25'h0, cur_f - 7'd1});
        if (seen_rise)
          chk(hi_cnt == 4, "R2 strobe high width", hi_cnt, 4);
      end
      prev_strb = pix_strobe;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; pwr_n = 1'b1; lane_in = '0; clk_lane = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_n = 1'b1; lane_in = '0; clk_lane = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_data == '0, "R7 data in reset", {4'h0, pix_data}, 0);
    chk(pix_strobe == 1'b0, "R7 strobe in reset", pix_strobe, 0);
    chk(locked == 1'b0, "R7 lock in reset", locked, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix_data == '0 && !pix_strobe && !locked, "R7 after release",
        {3'h0, locked, pix_data}, 0);
  endtask

  task automatic t_lock(input int off);
    int caps0;
    do_reset();
    for (int j = 7 - off; j < 7; j++) send_bit(next_f - 7'd1, j, 1'b0);
    send_frames(3);
    chk(locked == 1'b0, "R3 no lock before four matches", locked, 0);
    caps0 = cap_cnt;
    send_frames(9);
    chk(locked == 1'b1, "R8 lock from any phase", locked, 1);
    chk(cap_cnt > caps0, "R3 capture after lock", cap_cnt - caps0, 1);
  endtask

  task automatic t_miss();
    logic [27:0] held;
    send_frame(1'b1);
    send_frame(1'b0);
    chk(locked == 1'b1, "R4 single miss keeps lock", locked, 1);
    send_frames(3);
    send_frame(1'b1);
    send_frame(1'b1);
    send_frame(1'b0);
    chk(locked == 1'b0, "R4 two misses drop lock", locked, 0);
    held = pix_data;
    for (int i = 0; i < 2; i++) begin
      send_frame(1'b0);
      chk(pix_data == held, "R5 data frozen while unlocked",
          {4'h0, pix_data}, {4'h0, held});
      chk(pix_strobe == 1'b0, "R5 strobe low while unlocked", pix_strobe, 0);
    end
    send_frames(8);
    chk(locked == 1'b1, "R4 relock after search", locked, 1);
  endtask

  task automatic t_powerdown();
    logic [27:0] held;
    int caps0;
    pwr_n = 1'b0;
    held = pix_data;
    for (int i = 0; i < 3; i++) begin
      send_frame(1'b0);
      chk(pix_data == held, "R6 data frozen in power-down",
          {4'h0, pix_data}, {4'h0, held});
      chk(pix_strobe == 1'b0, "R6 strobe low in power-down", pix_strobe, 0);
    end
    chk(locked == 1'b1, "R6 lock kept in power-down", locked, 1);
    pwr_n = 1'b1;
    caps0 = cap_cnt;
    send_frames(3);
    chk(cap_cnt > caps0, "R6 capture resumes", cap_cnt - caps0, 1);
    chk(pix_data != held, "R6 new data after power-down",
        {4'h0, pix_data}, {4'h0, held});
  endtask

  initial begin
    t_reset();
    for (int off = 0; off < 7; off++) t_lock(off);
    t_miss();
    t_powerdown();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule